// File: doc/BRIEF.md
# Digital potentiometer register controller

This block is the register and control core of a single-channel digital potentiometer. It keeps a 7-bit live wiper code, a non-volatile start-up code, and a small control register. A serial bus front end has already parsed each bus transfer into an address, write data, a write strobe and a combinational read-data return. The block decodes these transfers and drives the tap code for the resistor ladder and a shutdown request line.

At power-up the live wiper starts at mid-scale. A short sequencer waits until the non-volatile storage reports that it can be read. It then copies the stored start-up code into the wiper and only after that opens the register file to bus writes. Address 0 holds both the live wiper and the stored start-up code, and a control bit chooses which of the two a transfer reaches. A write to the stored code also moves the live wiper at once. The new value is committed to storage after a programmable busy window. During that window a busy flag reads high and all register writes are dropped. A behavioural storage cell models the timed write and the ready indication.

Top module: `dpot_ctrl`

## Requirements
- R1: After reset the wiper output is 40h (mid-scale). The control register at address 2 reads 40h: select bit 7 = 0, enable bit 6 = 1, busy bit 5 = 0.
- R2: Once `nv_supply_ok` is high, the wiper output takes the stored start-up code (default 25h) within three clock edges and keeps it.
- R3: Bus writes made before the start-up recall has finished change neither the wiper nor the control register.
- R4: With control bit 7 = 1, a write to address 0 changes only the live wiper, and a read of address 0 returns the live wiper; the stored code is left unchanged.
- R5: With control bit 7 = 0, a write to address 0 sets the live wiper on the next clock edge and starts a non-volatile write of the same code.
- R6: After a non-volatile write begins, control bit 5 reads 1 for exactly NV_WR_CYCLES clock edges. During that window a read of address 0 (bit 7 = 0) returns the old stored code; afterwards it returns the new one.
- R7: While control bit 5 is 1, writes to address 0 and to address 2 have no effect.
- R8: `shutdown_o` is high when `shdn_req` is high or control bit 6 is 0.
- R9: Control bits 4..0 always read 0, and bit 5 cannot be written. Address 1 reads 00h, and writes to it change nothing.
- R10: A read of address 0 returns the 7-bit code with bit 7 = 0. A write to address 0 uses only data bits 6..0.
- R11: `wiper_o` always shows the live wiper code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| nv_supply_ok | input | 1 | Supply high enough for reliable storage reads |
| shdn_req | input | 1 | External shutdown request, active high |
| bus_addr | input | 2 | Register address from the bus front end |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| wiper_o | output | 7 | Tap code for the resistor ladder |
| shutdown_o | output | 1 | Shutdown request to the ladder |

## Verification
The hardest case to reach is the busy window of a non-volatile write. Writes that arrive inside the window must be dropped, while the old stored code stays visible until the commit. The bench starts a stored-code write and then, within the window, issues a control write that would switch the address-0 target and a second address-0 write. It then samples the busy bit one edge before and one edge after the commit. Only this edge-exact timing can tell dropped writes from writes that were merely deferred.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RSVD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  localparam int CTRL_SEL_BIT  = 7;
  localparam int CTRL_EN_BIT   = 6;
  localparam int CTRL_BUSY_BIT = 5;

  typedef enum logic [1:0] {
    SEQ_PRESET = 2'd0,
    SEQ_WAIT   = 2'd1,
    SEQ_RECALL = 2'd2,
    SEQ_RUN    = 2'd3
  } seq_state_e;

  function automatic logic [DATA_W-1:0] ctrl_pack(input logic sel, input logic en,
                                                  input logic busy);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CTRL_SEL_BIT]  = sel;
    v[CTRL_EN_BIT]   = en;
    v[CTRL_BUSY_BIT] = busy;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] code_widen(input logic [DATA_W-2:0] code);
    return {1'b0, code};
  endfunction
endpackage

// File: rtl/dpot_seq.sv
module dpot_seq
  import dpot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nv_ready,
  output seq_state_e state_o,
  output logic       recall_o,
  output logic       run_o
);
  seq_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_PRESET;
    end else begin
      unique case (state_q)
        SEQ_PRESET: state_q <= SEQ_WAIT;
        SEQ_WAIT:   if (nv_ready) state_q <= SEQ_RECALL;
        SEQ_RECALL: state_q <= SEQ_RUN;
        default:    state_q <= SEQ_RUN;
      endcase
    end
  end

  assign state_o  = state_q;
  assign recall_o = (state_q == SEQ_RECALL);
  assign run_o    = (state_q == SEQ_RUN);

  // Once running, the sequencer never falls back (R3)
  p_run_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |=> run_o);
endmodule

// File: rtl/dpot_nvcell.sv
module dpot_nvcell #(
  parameter int          CODE_W       = 7,
  parameter int          WR_CYCLES    = 200,
  parameter logic [CODE_W-1:0] INIT_CODE = 7'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              wr_start,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              ready_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CODE_W-1:0] mem_q;
  logic [CODE_W-1:0] pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              commit;

  assign busy_o  = (cnt_q != '0);
  assign commit  = (cnt_q == CNT_ONE);
  assign ready_o = supply_ok && !busy_o;
  assign rdata_o = mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= INIT_CODE;
      pend_q <= INIT_CODE;
      cnt_q  <= '0;
    end else begin
      if (wr_start && !busy_o) begin
        pend_q <= wr_data;
        cnt_q  <= CNT_LOAD;
      end else if (busy_o) begin
        cnt_q <= cnt_q - CNT_ONE;
        if (commit) mem_q <= pend_q;
      end
    end
  end

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !busy_o) |=> busy_o);
  p_commit_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (mem_q == pend_q));
  p_no_start_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !wr_start);
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              recall_en,
  input  logic [CODE_W-1:0] nv_rdata,
  input  logic              nv_busy,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              nv_wr_start,
  output logic [CODE_W-1:0] nv_wr_data,
  output logic [CODE_W-1:0] wiper_o,
  output logic              en_o
);
  localparam logic [CODE_W-1:0] PRESET_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] wiper_q;
  logic              sel_q;
  logic              en_q;
  logic              accept;
  logic              wr_live;
  logic              wr_stored;
  logic              wr_ctrl;

  assign accept    = bus_we && run && !nv_busy;
  assign wr_live   = accept && (bus_addr == ADDR_CODE) && sel_q;
  assign wr_stored = accept && (bus_addr == ADDR_CODE) && !sel_q;
  assign wr_ctrl   = accept && (bus_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= PRESET_CODE;
      sel_q   <= 1'b0;
      en_q    <= 1'b1;
    end else begin
      if (recall_en) begin
        wiper_q <= nv_rdata;
      end else if (wr_live || wr_stored) begin
        wiper_q <= bus_wdata[CODE_W-1:0];
      end
      if (wr_ctrl) begin
        sel_q <= bus_wdata[CTRL_SEL_BIT];
        en_q  <= bus_wdata[CTRL_EN_BIT];
      end
    end
  end

  assign nv_wr_start = wr_stored;
  assign nv_wr_data  = bus_wdata[CODE_W-1:0];
  assign wiper_o     = wiper_q;
  assign en_o        = en_q;

  always_comb begin
    unique case (bus_addr)
      ADDR_CODE: bus_rdata = code_widen(sel_q ? wiper_q : nv_rdata);
      ADDR_CTRL: bus_rdata = ctrl_pack(sel_q, en_q, nv_busy);
      default:   bus_rdata = '0;
    endcase
  end

  p_busy_hold_wiper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && run) |=> $stable(wiper_q));
  p_busy_hold_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> $stable({sel_q, en_q}));
  p_closed_before_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !recall_en) |=> ($stable(wiper_q) && $stable({sel_q, en_q})));
  p_stored_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stored |=> (wiper_q == $past(bus_wdata[CODE_W-1:0])));
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int                CODE_W       = 7,
  parameter int                NV_WR_CYCLES = 200,
  parameter logic [CODE_W-1:0] NV_INIT      = 7'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_supply_ok,
  input  logic              shdn_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CODE_W-1:0] wiper_o,
  output logic              shutdown_o
);
  localparam logic [CODE_W-1:0] PRESET_CODE = CODE_W'(1) << (CODE_W - 1);

  seq_state_e        seq_state;
  logic              seq_recall;
  logic              seq_run;
  logic              nv_ready;
  logic              nv_busy;
  logic [CODE_W-1:0] nv_rdata;
  logic              nv_wr_start;
  logic [CODE_W-1:0] nv_wr_data;
  logic              ctrl_en;

  dpot_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .nv_ready (nv_ready),
    .state_o  (seq_state),
    .recall_o (seq_recall),
    .run_o    (seq_run)
  );

  dpot_nvcell #(
    .CODE_W    (CODE_W),
    .WR_CYCLES (NV_WR_CYCLES),
    .INIT_CODE (NV_INIT)
  ) u_nv (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (nv_supply_ok),
    .wr_start  (nv_wr_start),
    .wr_data   (nv_wr_data),
    .rdata_o   (nv_rdata),
    .busy_o    (nv_busy),
    .ready_o   (nv_ready)
  );

  dpot_regs #(
    .CODE_W (CODE_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (seq_run),
    .recall_en   (seq_recall),
    .nv_rdata    (nv_rdata),
    .nv_busy     (nv_busy),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .nv_wr_start (nv_wr_start),
    .nv_wr_data  (nv_wr_data),
    .wiper_o     (wiper_o),
    .en_o        (ctrl_en)
  );

  assign shutdown_o = shdn_req || !ctrl_en;

  p_preset_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != SEQ_RUN && !seq_recall && seq_state != SEQ_RECALL) |-> (wiper_o == PRESET_CODE));
  p_recall_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_recall |=> (wiper_o == $past(nv_rdata)));
  p_pin_shutdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_req |-> shutdown_o);
endmodule

// File: tb/dpot_ctrl_bench.sv
module dpot_ctrl_bench;
  localparam int        NWR  = 12;
  localparam logic [6:0] INIT = 7'h25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nv_supply_ok = 1'b0;
  logic       shdn_req = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [6:0] wiper_o;
  logic       shutdown_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dpot_ctrl #(.CODE_W(7), .NV_WR_CYCLES(NWR), .NV_INIT(INIT)) u_dpot_ctrl (
    .clk(clk), .rst_n(rst_n), .nv_supply_ok(nv_supply_ok), .shdn_req(shdn_req),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .wiper_o(wiper_o), .shutdown_o(shutdown_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge; returns at the following negedge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] ctrl_exp(input logic sel, input logic en, input logic busy);
    return {sel, en, busy, 5'b00000};
  endfunction

  task automatic t_reset_and_gate();
    logic [7:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 wiper preset", {1'b0, wiper_o}, 8'h40);
    rd(2'd2, v); check("R1 ctrl reset", v, ctrl_exp(1'b0, 1'b1, 1'b0));
    check("R8 no shutdown at reset", {7'b0, shutdown_o}, 8'h00);
    wr(2'd2, 8'h80);
    rd(2'd2, v); check("R3 ctrl write before run", v, 8'h40);
    wr(2'd0, 8'h11);
    check("R3 wiper write before run", {1'b0, wiper_o}, 8'h40);
  endtask

  task automatic t_recall();
    logic [7:0] v;
    nv_supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 recalled code", {1'b0, wiper_o}, {1'b0, INIT});
    repeat (2) @(negedge clk);
    check("R2 recalled code held", {1'b0, wiper_o}, {1'b0, INIT});
    rd(2'd0, v); check("R10 stored code zero-extended", v, {1'b0, INIT});
  endtask

  task automatic t_live_only();
    logic [7:0] v;
    wr(2'd2, 8'hDF);
    rd(2'd2, v); check("R9 low bits and busy not writable", v, ctrl_exp(1'b1, 1'b1, 1'b0));
    wr(2'd0, 8'hFF);
    check("R11 wiper output after live write", {1'b0, wiper_o}, 8'h7F);
    rd(2'd0, v); check("R4 R10 live read", v, 8'h7F);
    wr(2'd0, 8'h92);
    check("R10 only low bits used", {1'b0, wiper_o}, 8'h12);
    wr(2'd2, 8'h40);
    rd(2'd0, v); check("R4 stored code untouched", v, {1'b0, INIT});
    check("R4 wiper kept after select change", {1'b0, wiper_o}, 8'h12);
  endtask

  task automatic t_stored_write();
    logic [7:0] v;
    wr(2'd0, 8'h8A);
    check("R5 wiper follows stored write", {1'b0, wiper_o}, 8'h0A);
    rd(2'd2, v); check("R6 busy set", v, ctrl_exp(1'b0, 1'b1, 1'b1));
    rd(2'd0, v); check("R6 old stored code during busy", v, {1'b0, INIT});
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h33);
    rd(2'd2, v); check("R7 ctrl write dropped in busy", v, ctrl_exp(1'b0, 1'b1, 1'b1));
    check("R7 wiper write dropped in busy", {1'b0, wiper_o}, 8'h0A);
    repeat (NWR - 3) @(negedge clk);
    rd(2'd2, v); check("R6 busy on last window edge", v, ctrl_exp(1'b0, 1'b1, 1'b1));
    @(negedge clk);
    rd(2'd2, v); check("R6 busy cleared", v, ctrl_exp(1'b0, 1'b1, 1'b0));
    rd(2'd0, v); check("R6 R7 committed code", v, 8'h0A);
    check("R11 wiper after commit", {1'b0, wiper_o}, 8'h0A);
  endtask

  task automatic t_shutdown();
    logic [7:0] v;
    shdn_req = 1'b1; #1;
    check("R8 pin shutdown", {7'b0, shutdown_o}, 8'h01);
    @(negedge clk);
    shdn_req = 1'b0; #1;
    check("R8 pin released", {7'b0, shutdown_o}, 8'h00);
    @(negedge clk);
    wr(2'd2, 8'h00);
    check("R8 bit shutdown", {7'b0, shutdown_o}, 8'h01);
    rd(2'd2, v); check("R8 enable bit cleared", v, 8'h00);
    wr(2'd2, 8'h40);
    check("R8 bit released", {7'b0, shutdown_o}, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R9 reserved reads zero", v, 8'h00);
    rd(2'd2, v); check("R9 reserved write no ctrl effect", v, 8'h40);
    check("R9 reserved write no wiper effect", {1'b0, wiper_o}, 8'h0A);
  endtask

  initial begin
    t_reset_and_gate();
    t_recall();
    t_live_only();
    t_stored_write();
    t_shutdown();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule